// File: doc/BRIEF.md
# Migrated-Line Location Tag Table

This block is a small per-tile directory of cache lines that have moved away from their home tile. A requester checks its own table before it sends anything toward a line's home tile: on a hit the request goes straight to the tile that holds the line now, and on a miss it takes the slower path through the home tile, which answers with the line's location. That location is then written back into the table as a remote entry. Message transport and the data cache lie outside this block.

The table is fully associative and holds two classes of entry. A local entry describes a line whose home is this tile but which now lives elsewhere. It carries a sharer mask with one bit per tile, marking every tile that holds a remote copy of the entry. A remote entry caches the location of a line homed on another tile. A new entry takes a free slot if one exists. Otherwise it displaces the least recently used remote entry. Local entries are never displaced. When a line homed here migrates again or returns home, the block puts out the sharer mask so that those tiles can be sent invalidations.

There is one lookup port and one modify port, and both can be used in the same cycle. Lookup results are registered. Every command acts on the table at the clock edge, so a lookup always sees the table as it was before any command issued in the same cycle.

Top module: `migtag_table`

## Requirements
- R1: A lookup with `lk_valid` high raises `lk_hit` in the next cycle if a valid entry of either class holds `lk_tag`, with `lk_host` giving that entry's host tile. On a miss, or with no lookup, `lk_hit` is 0 and `lk_host` is 0.
- R2: While a free slot exists, a remote insert (op 0) or a local insert (op 1) of a new tag always succeeds and displaces nothing. Eight remote inserts of distinct tags into an empty table therefore all stay visible to lookup.
- R3: When no slot is free, an insert of a new tag displaces the remote entry that was least recently used. Local entries are never displaced, and only op 3 removes them.
- R4: A remote insert and a lookup hit on a remote entry both make that entry most recently used. A lookup hit that coincides with any valid command leaves the recency order unchanged. Lookup hits on local entries never affect the order.
- R5: If all slots hold local entries, an insert of a new tag is dropped. `ovf` pulses high for one cycle in the cycle after the command, and the table does not change.
- R6: An insert of a tag that is already present never creates a second entry. A remote insert (op 0) updates only the host. A local insert (op 1) sets the host, turns the entry local and keeps its mask. If the entry was remote, it also clears the mask.
- R7: Op 4 sets bit `mod_tile` of a local entry's sharer mask, where bit i stands for tile i. Op 2 (migrate) replaces a local entry's host with `mod_tile` and clears its mask. If the old mask was nonzero, in the next cycle it pulses `inv_valid` with `inv_mask` equal to the old mask and `inv_tag` equal to the tag.
- R8: Op 3 (drop) removes a local entry. If its mask was nonzero, op 3 pulses `inv_valid`, `inv_mask` and `inv_tag` in the same way as op 2.
- R9: Op 5 removes a matching remote entry. On a local entry, or on a tag that is absent, op 5 has no effect. Ops 2, 3 and 4 have no effect on remote entries, and op codes 6 and 7 do nothing.
- R10: A command takes effect at the clock edge that samples it. A lookup issued in the same cycle returns the old contents, and a lookup issued in the following cycle returns the new contents.
- R11: After reset the table is empty and `lk_hit`, `lk_host`, `ovf`, `inv_valid`, `inv_tag` and `inv_mask` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_tag | input | TAG_W | Tag to look up |
| lk_hit | output | 1 | Lookup hit, one cycle after the request |
| lk_host | output | HOST_W | Host tile of the hit entry |
| mod_valid | input | 1 | Command request |
| mod_op | input | 3 | 0 insert remote, 1 insert local, 2 migrate, 3 drop local, 4 add sharer, 5 invalidate remote |
| mod_tag | input | TAG_W | Tag the command acts on |
| mod_tile | input | HOST_W | New host tile, or sharer tile for op 4 |
| ovf | output | 1 | Insert dropped because the table is full of local entries |
| inv_valid | output | 1 | Invalidations are to be sent |
| inv_tag | output | TAG_W | Tag to invalidate at the sharers |
| inv_mask | output | NTILE | Tiles to send invalidations to |

## Verification
An error in the recency ages does not show at once. It shows only when the table next fills and an insert displaces the wrong remote line, so that a later lookup of a line that should still be present misses. For that reason the stimulus keeps the table full for long stretches and looks up recently used tags right after each eviction. A corrupted entry class shows as a local line that disappears under eviction pressure, or as op 5 removing something it should leave alone. A wrong sharer mask shows in the cycle after the next migrate or drop, as the wrong `inv_mask`. Lookups issued together with a command, and in the cycle after it, pin down the edge at which each change takes effect.

// File: rtl/mtt_pkg.sv
package mtt_pkg;
    typedef enum logic [2:0] {
        OP_INS_REM  = 3'd0,
        OP_INS_LOC  = 3'd1,
        OP_MIGRATE  = 3'd2,
        OP_LOC_DROP = 3'd3,
        OP_ADD_SHR  = 3'd4,
        OP_REM_INV  = 3'd5
    } mtt_op_e;
endpackage

// File: rtl/mtt_cam.sv
module mtt_cam #(
    parameter int WAYS  = 8,
    parameter int TAG_W = 20,
    localparam int IDX_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0]            vld,
    input  logic [WAYS-1:0][TAG_W-1:0] tags,
    input  logic [TAG_W-1:0]           key,
    output logic [WAYS-1:0]            match,
    output logic                       hit,
    output logic [IDX_W-1:0]           idx
);
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign match[w] = vld[w] && (tags[w] == key);
    end

    assign hit = |match;

    always_comb begin
        idx = '0;
        for (int i = 0; i < WAYS; i++) begin
            if (match[i]) idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/mtt_pick.sv
module mtt_pick #(
    parameter int WAYS = 8,
    localparam int IDX_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0]            vld,
    input  logic [WAYS-1:0]            loc,
    input  logic [WAYS-1:0][IDX_W-1:0] ages,
    output logic                       free_any,
    output logic [IDX_W-1:0]           free_idx,
    output logic                       rem_any,
    output logic [IDX_W-1:0]           victim_idx
);
    logic [WAYS-1:0] rem;
    assign rem = vld & ~loc;

    // lowest-numbered empty slot
    always_comb begin
        free_any = ~&vld;
        free_idx = '0;
        for (int i = WAYS - 1; i >= 0; i--) begin
            if (!vld[i]) free_idx = IDX_W'(i);
        end
    end

    // oldest remote entry
    always_comb begin
        rem_any    = |rem;
        victim_idx = '0;
        for (int i = 0; i < WAYS; i++) begin
            if (rem[i] && (!rem[victim_idx] || ages[i] > ages[victim_idx]))
                victim_idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/mtt_lru.sv
module mtt_lru #(
    parameter int WAYS = 8,
    localparam int IDX_W = $clog2(WAYS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [WAYS-1:0]            rem_vld,
    input  logic                       touch_en,
    input  logic                       remove_en,
    input  logic [IDX_W-1:0]           way,
    output logic [WAYS-1:0][IDX_W-1:0] ages
);
    logic [WAYS-1:0][IDX_W-1:0] age_q;
    logic [IDX_W:0]             rem_cnt;
    logic [IDX_W:0]             ref_age;

    assign rem_cnt = (IDX_W+1)'($countones(rem_vld));
    // an entry that is new to the remote set ranks behind every current one
    assign ref_age = rem_vld[way] ? {1'b0, age_q[way]} : rem_cnt;
    assign ages    = age_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            age_q <= '0;
        end else if (touch_en) begin
            for (int j = 0; j < WAYS; j++) begin
                if (IDX_W'(j) == way)
                    age_q[j] <= '0;
                else if (rem_vld[j] && ({1'b0, age_q[j]} < ref_age))
                    age_q[j] <= age_q[j] + IDX_W'(1);
            end
        end else if (remove_en) begin
            for (int j = 0; j < WAYS; j++) begin
                if (rem_vld[j] && (IDX_W'(j) != way) && (age_q[j] > age_q[way]))
                    age_q[j] <= age_q[j] - IDX_W'(1);
            end
        end
    end
endmodule

// File: rtl/migtag_table.sv
module migtag_table #(
    parameter int WAYS  = 8,
    parameter int TAG_W = 20,
    parameter int NTILE = 16,
    localparam int HOST_W = $clog2(NTILE),
    localparam int IDX_W  = $clog2(WAYS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [TAG_W-1:0]  lk_tag,
    output logic              lk_hit,
    output logic [HOST_W-1:0] lk_host,
    input  logic              mod_valid,
    input  logic [2:0]        mod_op,
    input  logic [TAG_W-1:0]  mod_tag,
    input  logic [HOST_W-1:0] mod_tile,
    output logic              ovf,
    output logic              inv_valid,
    output logic [TAG_W-1:0]  inv_tag,
    output logic [NTILE-1:0]  inv_mask
);
    import mtt_pkg::*;

    // entry storage
    logic [WAYS-1:0]             vld_q, loc_q;
    logic [WAYS-1:0][TAG_W-1:0]  tag_q;
    logic [WAYS-1:0][HOST_W-1:0] host_q;
    logic [WAYS-1:0][NTILE-1:0]  mask_q;

    mtt_op_e op;
    assign op = mtt_op_e'(mod_op);

    logic [WAYS-1:0]  l_match, m_match;
    logic             l_hit, m_hit;
    logic [IDX_W-1:0] l_idx, m_idx;

    mtt_cam #(.WAYS(WAYS), .TAG_W(TAG_W)) u_cam_lk (
        .vld(vld_q), .tags(tag_q), .key(lk_tag),
        .match(l_match), .hit(l_hit), .idx(l_idx)
    );
    mtt_cam #(.WAYS(WAYS), .TAG_W(TAG_W)) u_cam_mod (
        .vld(vld_q), .tags(tag_q), .key(mod_tag),
        .match(m_match), .hit(m_hit), .idx(m_idx)
    );

    logic [WAYS-1:0][IDX_W-1:0] ages;
    logic                       free_any, rem_any;
    logic [IDX_W-1:0]           free_idx, victim_idx;

    mtt_pick #(.WAYS(WAYS)) u_pick (
        .vld(vld_q), .loc(loc_q), .ages(ages),
        .free_any(free_any), .free_idx(free_idx),
        .rem_any(rem_any), .victim_idx(victim_idx)
    );

    logic             touch_en, remove_en;
    logic [IDX_W-1:0] lru_way;

    mtt_lru #(.WAYS(WAYS)) u_lru (
        .clk(clk), .rst_n(rst_n), .rem_vld(vld_q & ~loc_q),
        .touch_en(touch_en), .remove_en(remove_en), .way(lru_way), .ages(ages)
    );

    // next-state of one entry per cycle
    logic              wr_en;
    logic [IDX_W-1:0]  wr_idx;
    logic              n_vld, n_loc;
    logic [TAG_W-1:0]  n_tag;
    logic [HOST_W-1:0] n_host;
    logic [NTILE-1:0]  n_mask;
    logic              ovf_d, inv_d;
    logic [IDX_W-1:0]  new_idx;
    logic              new_ok;

    assign new_ok  = free_any || rem_any;
    assign new_idx = free_any ? free_idx : victim_idx;

    always_comb begin
        wr_en     = 1'b0;
        wr_idx    = m_idx;
        n_vld     = vld_q[m_idx];
        n_loc     = loc_q[m_idx];
        n_tag     = tag_q[m_idx];
        n_host    = host_q[m_idx];
        n_mask    = mask_q[m_idx];
        touch_en  = 1'b0;
        remove_en = 1'b0;
        lru_way   = m_idx;
        ovf_d     = 1'b0;
        inv_d     = 1'b0;
        if (mod_valid) begin
            unique case (op)
                OP_INS_REM: begin
                    if (m_hit) begin
                        wr_en  = 1'b1;
                        n_host = mod_tile;
                        touch_en = !loc_q[m_idx];
                    end else if (new_ok) begin
                        wr_en    = 1'b1;
                        wr_idx   = new_idx;
                        n_vld    = 1'b1;
                        n_loc    = 1'b0;
                        n_tag    = mod_tag;
                        n_host   = mod_tile;
                        n_mask   = '0;
                        touch_en = 1'b1;
                        lru_way  = new_idx;
                    end else begin
                        ovf_d = 1'b1;
                    end
                end
                OP_INS_LOC: begin
                    if (m_hit) begin
                        wr_en  = 1'b1;
                        n_host = mod_tile;
                        n_loc  = 1'b1;
                        if (!loc_q[m_idx]) begin
                            n_mask    = '0;
                            remove_en = 1'b1;
                        end
                    end else if (new_ok) begin
                        wr_en     = 1'b1;
                        wr_idx    = new_idx;
                        n_vld     = 1'b1;
                        n_loc     = 1'b1;
                        n_tag     = mod_tag;
                        n_host    = mod_tile;
                        n_mask    = '0;
                        remove_en = !free_any;
                        lru_way   = new_idx;
                    end else begin
                        ovf_d = 1'b1;
                    end
                end
                OP_MIGRATE: begin
                    if (m_hit && loc_q[m_idx]) begin
                        wr_en  = 1'b1;
                        n_host = mod_tile;
                        n_mask = '0;
                        inv_d  = |mask_q[m_idx];
                    end
                end
                OP_LOC_DROP: begin
                    if (m_hit && loc_q[m_idx]) begin
                        wr_en  = 1'b1;
                        n_vld  = 1'b0;
                        n_mask = '0;
                        inv_d  = |mask_q[m_idx];
                    end
                end
                OP_ADD_SHR: begin
                    if (m_hit && loc_q[m_idx]) begin
                        wr_en            = 1'b1;
                        n_mask[mod_tile] = 1'b1;
                    end
                end
                OP_REM_INV: begin
                    if (m_hit && !loc_q[m_idx]) begin
                        wr_en     = 1'b1;
                        n_vld     = 1'b0;
                        remove_en = 1'b1;
                    end
                end
                default: ;
            endcase
        end else if (lk_valid && l_hit && !loc_q[l_idx]) begin
            touch_en = 1'b1;
            lru_way  = l_idx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q  <= '0;
            loc_q  <= '0;
            tag_q  <= '0;
            host_q <= '0;
            mask_q <= '0;
        end else if (wr_en) begin
            vld_q[wr_idx]  <= n_vld;
            loc_q[wr_idx]  <= n_loc;
            tag_q[wr_idx]  <= n_tag;
            host_q[wr_idx] <= n_host;
            mask_q[wr_idx] <= n_mask;
        end
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lk_hit    <= 1'b0;
            lk_host   <= '0;
            ovf       <= 1'b0;
            inv_valid <= 1'b0;
            inv_tag   <= '0;
            inv_mask  <= '0;
        end else begin
            lk_hit    <= lk_valid && l_hit;
            lk_host   <= (lk_valid && l_hit) ? host_q[l_idx] : '0;
            ovf       <= ovf_d;
            inv_valid <= inv_d;
            inv_tag   <= inv_d ? mod_tag : '0;
            inv_mask  <= inv_d ? mask_q[m_idx] : '0;
        end
    end

    AST_LK_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> $past(lk_valid)); // R1
    AST_NO_DUP_TAG: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |-> $onehot0(l_match)); // R6
    AST_OVF_ONLY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |-> $past((&vld_q) && (&loc_q))); // R5
    AST_INV_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        inv_valid |-> $past(mod_valid && (mod_op == 3'd2 || mod_op == 3'd3))); // R7

    for (genvar w = 0; w < WAYS; w++) begin : g_keep
        AST_LOCAL_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
            (vld_q[w] && loc_q[w] && !(mod_valid && mod_op == 3'd3)) |=> vld_q[w]); // R3
    end
endmodule

// File: tb/migtag_table_tb_top.sv
module migtag_table_tb_top;
    localparam int WAYS = 8, TAG_W = 20, NTILE = 16, HOST_W = 4;

    logic              clk = 1'b0, rst_n = 1'b0;
    logic              lk_valid = 1'b0, mod_valid = 1'b0;
    logic [TAG_W-1:0]  lk_tag = '0, mod_tag = '0;
    logic [2:0]        mod_op = '0;
    logic [HOST_W-1:0] mod_tile = '0;
    logic              lk_hit, ovf, inv_valid;
    logic [HOST_W-1:0] lk_host;
    logic [TAG_W-1:0]  inv_tag;
    logic [NTILE-1:0]  inv_mask;

    always #2.5 clk = ~clk;

    migtag_table #(.WAYS(WAYS), .TAG_W(TAG_W), .NTILE(NTILE)) dut_i (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_tag(lk_tag),
        .lk_hit(lk_hit), .lk_host(lk_host), .mod_valid(mod_valid), .mod_op(mod_op),
        .mod_tag(mod_tag), .mod_tile(mod_tile), .ovf(ovf), .inv_valid(inv_valid),
        .inv_tag(inv_tag), .inv_mask(inv_mask)
    );

    int total = 0, bad = 0;

    // reference model: recency kept as a touch stamp
    bit          m_vld [WAYS];
    bit          m_loc [WAYS];
    int          m_tag [WAYS];
    int          m_host[WAYS];
    int          m_mask[WAYS];
    longint      m_stamp[WAYS];
    longint      stamp_ctr = 0;

    bit e_hit, e_ovf, e_inv;
    int e_host, e_imask, e_itag;

    function automatic int find(int t);
        for (int i = 0; i < WAYS; i++) if (m_vld[i] && m_tag[i] == t) return i;
        return -1;
    endfunction

    function automatic int slot_for_new();
        int v = -1;
        for (int i = 0; i < WAYS; i++) if (!m_vld[i]) return i;
        for (int i = 0; i < WAYS; i++)
            if (!m_loc[i] && (v < 0 || m_stamp[i] < m_stamp[v])) v = i;
        return v;
    endfunction

    function automatic void model(bit lv, int lt, bit mv, int op, int mt, int tile);
        int li = find(lt);
        int mi = find(mt);
        int s;
        e_hit = lv && li >= 0;
        e_host = e_hit ? m_host[li] : 0;
        e_ovf = 0; e_inv = 0; e_imask = 0; e_itag = 0;
        if (mv) begin
            case (op)
                0, 1: begin
                    if (mi >= 0) begin
                        m_host[mi] = tile;
                        if (op == 0 && !m_loc[mi]) m_stamp[mi] = ++stamp_ctr;
                        if (op == 1) begin
                            if (!m_loc[mi]) m_mask[mi] = 0;
                            m_loc[mi] = 1;
                        end
                    end else begin
                        s = slot_for_new();
                        if (s < 0) e_ovf = 1;
                        else begin
                            m_vld[s] = 1; m_loc[s] = (op == 1); m_tag[s] = mt;
                            m_host[s] = tile; m_mask[s] = 0; m_stamp[s] = ++stamp_ctr;
                        end
                    end
                end
                2, 3: if (mi >= 0 && m_loc[mi]) begin
                    e_inv = m_mask[mi] != 0;
                    e_imask = e_inv ? m_mask[mi] : 0;
                    e_itag = e_inv ? mt : 0;
                    m_mask[mi] = 0;
                    if (op == 2) m_host[mi] = tile; else m_vld[mi] = 0;
                end
                4: if (mi >= 0 && m_loc[mi]) m_mask[mi] = m_mask[mi] | (1 << tile);
                5: if (mi >= 0 && !m_loc[mi]) m_vld[mi] = 0;
                default: ;
            endcase
        end else if (e_hit && !m_loc[li]) begin
            m_stamp[li] = ++stamp_ctr;
        end
    endfunction

    task automatic chk(string req, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // one cycle: drive at negedge, compare after the sampling edge
    task automatic cyc(string req, bit lv, int lt, bit mv, int op, int mt, int tile);
        lk_valid = lv; lk_tag = TAG_W'(lt);
        mod_valid = mv; mod_op = 3'(op); mod_tag = TAG_W'(mt); mod_tile = HOST_W'(tile);
        model(lv, lt, mv, op, mt, tile);
        @(posedge clk);
        @(negedge clk);
        chk({req, "/R1"}, "lk_hit", int'(lk_hit), int'(e_hit));
        chk({req, "/R1"}, "lk_host", int'(lk_host), e_host);
        chk({req, "/R5"}, "ovf", int'(ovf), int'(e_ovf));
        chk({req, "/R7"}, "inv_valid", int'(inv_valid), int'(e_inv));
        chk({req, "/R7"}, "inv_mask", int'(inv_mask), e_imask);
        chk({req, "/R8"}, "inv_tag", int'(inv_tag), e_itag);
    endtask

    task automatic look(string req, int t);
        cyc(req, 1, t, 0, 0, 0, 0);
    endtask

    task automatic cmd(string req, int op, int t, int tile);
        cyc(req, 0, 0, 1, op, t, tile);
    endtask

    initial begin
        int unused_seed = $urandom(32'h5eed_0042);
        for (int i = 0; i < WAYS; i++) begin
            m_vld[i] = 0; m_loc[i] = 0; m_tag[i] = 0; m_host[i] = 0; m_mask[i] = 0; m_stamp[i] = 0;
        end
        repeat (3) @(negedge clk);
        chk("R11", "lk_hit", int'(lk_hit), 0);
        chk("R11", "lk_host", int'(lk_host), 0);
        chk("R11", "ovf", int'(ovf), 0);
        chk("R11", "inv_valid", int'(inv_valid), 0);
        chk("R11", "inv_tag", int'(inv_tag), 0);
        chk("R11", "inv_mask", int'(inv_mask), 0);
        rst_n = 1'b1;
        look("R11", 'h100);
        // R2: fill with remote entries, all stay visible
        for (int i = 0; i < 8; i++) cmd("R2", 0, 'h100 + i, i);
        for (int i = 0; i < 8; i++) look("R2", 'h100 + i);
        // R4/R3: refresh oldest, then evict the next oldest
        look("R4", 'h100);
        cmd("R3", 0, 'h108, 9);
        look("R3", 'h101);
        look("R3", 'h100);
        // R4: lookup together with a command does not refresh; R10 old contents seen
        cyc("R10", 1, 'h102, 1, 5, 'h105, 0);
        look("R9", 'h105);
        cmd("R4", 0, 'h109, 10);
        look("R4", 'h102);
        // local entry, sharers, migrate
        cmd("R2", 1, 'h200, 3);
        cmd("R7", 4, 'h200, 2);
        cmd("R7", 4, 'h200, 9);
        cyc("R10", 1, 'h200, 1, 2, 'h200, 7);
        look("R10", 'h200);
        cmd("R7", 2, 'h200, 8);
        cmd("R9", 5, 'h200, 0);
        look("R9", 'h200);
        cmd("R9", 4, 'h103, 1);
        cmd("R9", 6, 'h103, 1);
        look("R9", 'h103);
        // R6: reinsert present tag
        cmd("R6", 0, 'h100, 12);
        look("R6", 'h100);
        cmd("R6", 1, 'h104, 5);
        look("R6", 'h104);
        // R3/R5: fill with locals, then overflow
        for (int i = 1; i < 8; i++) cmd("R3", 1, 'h200 + i, i);
        for (int i = 0; i < 8; i++) look("R3", 'h200 + i);
        look("R3", 'h104);
        cmd("R5", 0, 'h300, 4);
        look("R5", 'h300);
        cmd("R5", 1, 'h301, 4);
        // R8: drop with sharers
        cmd("R8", 4, 'h203, 15);
        cmd("R8", 4, 'h203, 0);
        cmd("R8", 3, 'h203, 0);
        look("R8", 'h203);
        cmd("R8", 3, 'h202, 0);
        // random phase
        for (int n = 0; n < 4000; n++) begin
            int r = int'($urandom_range(0, 99));
            int op = r < 35 ? 0 : r < 50 ? 1 : r < 60 ? 2 : r < 68 ? 3 : r < 82 ? 4 : r < 97 ? 5 : 6;
            cyc("RND", $urandom_range(0, 3) != 0, 'h400 + int'($urandom_range(0, 13)),
                $urandom_range(0, 2) != 0, op, 'h400 + int'($urandom_range(0, 13)),
                int'($urandom_range(0, 15)));
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule